// File: doc/BRIEF.md
# USB OUT Endpoint Receive Bank Controller

This block manages the receive storage of one USB OUT endpoint. It has two data banks and can run with one or both of them. The packet-reception side opens a packet, streams its bytes in and closes it. For each packet the block answers ACK if a free bank took the packet, or NAK if no bank was free. On the CPU side the block shows four things: a receive-done flag, a bank-hold flag for the current bank, a read-allowed flag, and the number of bytes left in the current bank. The CPU drains the bank one byte at a time through a read strobe.

Software acknowledges a packet by clearing the receive-done flag. After that it releases the bank by clearing the bank-hold flag. The block enforces this order: a release request is ignored while receive-done is still set. In dual-bank operation a release moves the CPU to the other bank, and the flags reload from that bank's state. An optional auto-release mode frees the bank in hardware when the CPU reads its last byte. The interrupt output is the receive-done flag gated by an enable input.

Top module: `usb_out_bank_ctrl`

## Requirements
- R1: With `cfg_dual_bank`=1, two packets can be accepted before any release, and they fill the banks alternately. With `cfg_dual_bank`=0 only one bank is used, so a second packet arriving before the release is refused.
- R2: `hs_valid` pulses for one cycle, in the cycle after `pkt_end`. `hs_ack`=1 means ACK and `hs_ack`=0 means NAK. It is ACK exactly when the bank chosen at `pkt_start` was free at that time.
- R3: When an accepted packet is committed into the current bank, `rx_done` and `bank_ctl` are 1 in the following cycle.
- R4: `irq` equals `rx_done` AND `cfg_irq_en`.
- R5: `rx_done` is cleared only by `cpu_clr_rx_done`, in both modes. It holds its value otherwise.
- R6: A `cpu_clr_bank_ctl` strobe is ignored while `rx_done`=1 or `bank_ctl`=0. The bank stays held and its data stays readable.
- R7: An accepted release frees the current bank. In dual-bank operation it also moves to the other bank. `bank_ctl` then shows whether the new current bank is full, and `rx_done` is set if that bank holds a packet.
- R8: `rd_allowed` is 1 exactly when the current bank is full and `byte_count` is non-zero.
- R9: `byte_count` is the number of unread bytes in the current bank. A `cpu_rd` strobe while `rd_allowed`=1 places the next byte, in arrival order, on `cpu_rd_data` in the following cycle and decrements `byte_count`. A released bank reports 0.
- R10: A `cpu_rd` strobe while `rd_allowed`=0 puts 0 on `cpu_rd_data` and changes no flag or count.
- R11: With `cfg_auto_release`=1, the read that empties the current bank also releases it, as in R7, even if `rx_done` is still set.
- R12: Bytes beyond `BANK_BYTES` in one packet are dropped. The count saturates at `BANK_BYTES` and the packet is still ACKed.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| cfg_dual_bank | input | 1 | 1: use both banks; 0: single bank |
| cfg_auto_release | input | 1 | 1: release a bank in hardware when it is read empty |
| cfg_irq_en | input | 1 | Interrupt enable for receive-done |
| pkt_start | input | 1 | Start of an OUT data packet |
| pkt_byte_vld | input | 1 | Packet byte strobe |
| pkt_byte | input | DATA_W | Packet byte |
| pkt_end | input | 1 | End of a good packet |
| hs_valid | output | 1 | Handshake decision valid |
| hs_ack | output | 1 | 1 = ACK, 0 = NAK |
| cpu_clr_rx_done | input | 1 | Strobe clearing receive-done |
| cpu_clr_bank_ctl | input | 1 | Strobe clearing bank-hold (release) |
| cpu_rd | input | 1 | Data port read strobe |
| cpu_rd_data | output | DATA_W | Read byte, valid the cycle after `cpu_rd` |
| rx_done | output | 1 | Receive-done flag |
| bank_ctl | output | 1 | Current bank is held (full) |
| rd_allowed | output | 1 | Current bank has bytes to read |
| byte_count | output | CNT_W | Unread bytes in current bank |
| irq | output | 1 | Endpoint interrupt |

## Verification
The bench builds the block with `BANK_BYTES`=8. At that size, packets longer than a bank are cheap to send, so overflow and saturation of the count come up often, both in directed cases and in random lengths. A byte count of exactly one bank is also common. Random sequences run in all four combinations of single/dual bank and manual/auto release. These sequences make NAKs on full banks, ignored out-of-order releases and reads from empty banks frequent.

// File: rtl/usb_obc_pkg.sv
// Shared constants and types for the OUT endpoint bank controller.
package usb_obc_pkg;
    // Number of physical banks; single-bank operation uses bank 0 only.
    localparam int NUM_BANKS = 2;
    // Bank index type (two banks).
    typedef logic bank_t;
endpackage

// File: rtl/obc_fill_ctrl.sv
// Packet-side fill controller.
// Chooses a target bank at packet start, writes the packet's bytes into it,
// commits the bank at packet end and issues the ACK/NAK decision.
// Assumes pkt_end comes after the last byte and never in the same cycle as
// pkt_start. BANK_BYTES is a power of two, at least 2.
module obc_fill_ctrl
    import usb_obc_pkg::*;
#(
    parameter int BANK_BYTES = 64,
    parameter int DATA_W     = 8,
    parameter int CNT_W      = $clog2(BANK_BYTES + 1),
    parameter int AW         = $clog2(BANK_BYTES)
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 dual,
    input  logic                 pkt_start,
    input  logic                 pkt_byte_vld,
    input  logic [DATA_W-1:0]    pkt_byte,
    input  logic                 pkt_end,
    input  logic [NUM_BANKS-1:0] bank_full,
    output logic                 wr_en,
    output bank_t                wr_bank,
    output logic [AW-1:0]        wr_addr,
    output logic [DATA_W-1:0]    wr_data,
    output logic                 commit,
    output bank_t                commit_bank,
    output logic [CNT_W-1:0]     commit_count,
    output logic                 hs_valid,
    output logic                 hs_ack
);
    localparam logic [CNT_W-1:0] BANK_LIMIT = CNT_W'(BANK_BYTES);

    logic              active_q;
    logic              accept_q;
    bank_t             tgt_q;
    bank_t             fill_sel_q;
    logic [CNT_W-1:0]  wptr_q;
    bank_t             sel;

    // Bank offered to a new packet: alternates in dual mode, else bank 0.
    always_comb sel = dual ? fill_sel_q : 1'b0;

    // Byte write enable; bytes past the bank size are dropped.
    always_comb begin
        wr_en   = active_q && accept_q && pkt_byte_vld && (wptr_q < BANK_LIMIT);
        wr_bank = tgt_q;
        wr_addr = wptr_q[AW-1:0];
        wr_data = pkt_byte;
    end

    // Commit of an accepted packet on its end strobe.
    always_comb begin
        commit       = active_q && accept_q && pkt_end;
        commit_bank  = tgt_q;
        commit_count = wptr_q;
    end

    // Packet tracking, write pointer, fill alternation and handshake.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            active_q   <= 1'b0;
            accept_q   <= 1'b0;
            tgt_q      <= 1'b0;
            fill_sel_q <= 1'b0;
            wptr_q     <= '0;
            hs_valid   <= 1'b0;
            hs_ack     <= 1'b0;
        end else begin
            hs_valid <= 1'b0;
            if (pkt_start) begin
                active_q <= 1'b1;
                accept_q <= !bank_full[sel];
                tgt_q    <= sel;
                wptr_q   <= '0;
            end else if (active_q) begin
                if (wr_en) begin
                    wptr_q <= wptr_q + CNT_W'(1);
                end
                if (pkt_end) begin
                    active_q <= 1'b0;
                    hs_valid <= 1'b1;
                    hs_ack   <= accept_q;
                    if (accept_q && dual) begin
                        fill_sel_q <= ~fill_sel_q;
                    end
                end
            end
        end
    end
endmodule

// File: rtl/obc_bank_store.sv
// Two-bank byte storage with one write port and one registered read port.
// A read of an empty bank (rd_zero) returns zero.
// Assumes the writer and the reader never address the same bank together.
module obc_bank_store
    import usb_obc_pkg::*;
#(
    parameter int BANK_BYTES = 64,
    parameter int DATA_W     = 8,
    parameter int AW         = $clog2(BANK_BYTES)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en,
    input  bank_t             wr_bank,
    input  logic [AW-1:0]     wr_addr,
    input  logic [DATA_W-1:0] wr_data,
    input  logic              rd_en,
    input  logic              rd_zero,
    input  bank_t             rd_bank,
    input  logic [AW-1:0]     rd_addr,
    output logic [DATA_W-1:0] rd_data
);
    localparam int DEPTH = NUM_BANKS * BANK_BYTES;

    logic [DATA_W-1:0] mem_q [DEPTH];

    // Store packet bytes; storage needs no reset.
    always_ff @(posedge clk) begin
        if (wr_en) begin
            mem_q[{wr_bank, wr_addr}] <= wr_data;
        end
    end

    // Registered data port: next byte on a valid read, zero on an empty read.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            rd_data <= '0;
        end else if (rd_en) begin
            rd_data <= mem_q[{rd_bank, rd_addr}];
        end else if (rd_zero) begin
            rd_data <= '0;
        end
    end
endmodule

// File: rtl/obc_bank_seq.sv
// CPU-side bank sequencer.
// Tracks per-bank full state and remaining counts, the current bank, the
// receive-done flag and the read pointer. Handles manual release (ignored
// while receive-done is set) and auto-release on the last read.
// Assumes mode inputs only change while in reset.
module obc_bank_seq
    import usb_obc_pkg::*;
#(
    parameter int BANK_BYTES = 64,
    parameter int CNT_W      = $clog2(BANK_BYTES + 1),
    parameter int AW         = $clog2(BANK_BYTES)
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 dual,
    input  logic                 auto_rel,
    input  logic                 commit,
    input  bank_t                commit_bank,
    input  logic [CNT_W-1:0]     commit_count,
    input  logic                 clr_rx,
    input  logic                 clr_ctl,
    input  logic                 cpu_rd,
    output logic [NUM_BANKS-1:0] bank_full,
    output bank_t                cur_bank,
    output logic [AW-1:0]        rd_ptr,
    output logic                 rd_fire,
    output logic                 rd_empty,
    output logic                 rx_flag,
    output logic                 ctl_flag,
    output logic                 rwal_flag,
    output logic [CNT_W-1:0]     cur_count
);
    logic [NUM_BANKS-1:0] full_nxt;
    logic [CNT_W-1:0]     rem_q [NUM_BANKS];
    logic                 release_now;
    bank_t                cur_nxt;
    logic                 rx_set;

    // Current-bank view presented to the CPU.
    always_comb begin
        ctl_flag  = bank_full[cur_bank];
        cur_count = rem_q[cur_bank];
        rwal_flag = ctl_flag && (cur_count != '0);
        rd_fire   = cpu_rd && rwal_flag;
        rd_empty  = cpu_rd && !rwal_flag;
    end

    // Release decision: ordered manual clear, or last byte read in auto mode.
    always_comb begin
        release_now = (clr_ctl && ctl_flag && !rx_flag)
                    || (auto_rel && rd_fire && (cur_count == CNT_W'(1)));
        cur_nxt     = release_now ? (dual ? ~cur_bank : 1'b0) : cur_bank;
    end

    // Per-bank full state and remaining count.
    for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
        logic is_cur;
        logic is_commit;

        // Decode whether this bank is current or being committed.
        always_comb begin
            is_cur    = (cur_bank == bank_t'(b));
            is_commit = commit && (commit_bank == bank_t'(b));
        end

        // Next full state: set on commit, cleared on release of this bank.
        always_comb begin
            if (is_commit)                full_nxt[b] = 1'b1;
            else if (release_now && is_cur) full_nxt[b] = 1'b0;
            else                          full_nxt[b] = bank_full[b];
        end

        // Full flag register.
        always_ff @(posedge clk) begin
            if (!rst_n) bank_full[b] <= 1'b0;
            else        bank_full[b] <= full_nxt[b];
        end

        // Remaining-byte counter: load on commit, count down on reads, zero on release.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                rem_q[b] <= '0;
            end else if (is_commit) begin
                rem_q[b] <= commit_count;
            end else if (release_now && is_cur) begin
                rem_q[b] <= '0;
            end else if (rd_fire && is_cur) begin
                rem_q[b] <= rem_q[b] - CNT_W'(1);
            end
        end
    end

    // Receive-done is raised when the (new) current bank gets or holds a packet.
    always_comb begin
        rx_set = (commit && (commit_bank == cur_nxt))
               || (release_now && full_nxt[cur_nxt]);
    end

    // Current bank, read pointer and receive-done flag.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            cur_bank <= 1'b0;
            rd_ptr   <= '0;
            rx_flag  <= 1'b0;
        end else begin
            cur_bank <= cur_nxt;
            if (release_now)  rd_ptr <= '0;
            else if (rd_fire) rd_ptr <= rd_ptr + AW'(1);
            if (rx_set)       rx_flag <= 1'b1;
            else if (clr_rx)  rx_flag <= 1'b0;
        end
    end
endmodule

// File: rtl/usb_out_bank_ctrl.sv
// OUT endpoint receive bank controller (top).
// Connects the packet-side fill controller, the bank storage and the
// CPU-side sequencer, and gates the endpoint interrupt.
// Assumes BANK_BYTES is a power of two, at least 2, and configuration
// inputs are static outside reset.
module usb_out_bank_ctrl
    import usb_obc_pkg::*;
#(
    parameter int BANK_BYTES = 64,
    parameter int DATA_W     = 8,
    parameter int CNT_W      = $clog2(BANK_BYTES + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cfg_dual_bank,
    input  logic              cfg_auto_release,
    input  logic              cfg_irq_en,
    input  logic              pkt_start,
    input  logic              pkt_byte_vld,
    input  logic [DATA_W-1:0] pkt_byte,
    input  logic              pkt_end,
    output logic              hs_valid,
    output logic              hs_ack,
    input  logic              cpu_clr_rx_done,
    input  logic              cpu_clr_bank_ctl,
    input  logic              cpu_rd,
    output logic [DATA_W-1:0] cpu_rd_data,
    output logic              rx_done,
    output logic              bank_ctl,
    output logic              rd_allowed,
    output logic [CNT_W-1:0]  byte_count,
    output logic              irq
);
    localparam int AW = $clog2(BANK_BYTES);

    logic                 wr_en;
    bank_t                wr_bank;
    logic [AW-1:0]        wr_addr;
    logic [DATA_W-1:0]    wr_data;
    logic                 commit;
    bank_t                commit_bank;
    logic [CNT_W-1:0]     commit_count;
    logic [NUM_BANKS-1:0] bank_full;
    bank_t                cur_bank;
    logic [AW-1:0]        rd_ptr;
    logic                 rd_fire;
    logic                 rd_empty;

    obc_fill_ctrl #(
        .BANK_BYTES(BANK_BYTES), .DATA_W(DATA_W), .CNT_W(CNT_W), .AW(AW)
    ) u_fill (
        .clk(clk), .rst_n(rst_n), .dual(cfg_dual_bank),
        .pkt_start(pkt_start), .pkt_byte_vld(pkt_byte_vld),
        .pkt_byte(pkt_byte), .pkt_end(pkt_end), .bank_full(bank_full),
        .wr_en(wr_en), .wr_bank(wr_bank), .wr_addr(wr_addr),
        .wr_data(wr_data), .commit(commit), .commit_bank(commit_bank),
        .commit_count(commit_count), .hs_valid(hs_valid), .hs_ack(hs_ack)
    );

    obc_bank_store #(
        .BANK_BYTES(BANK_BYTES), .DATA_W(DATA_W), .AW(AW)
    ) u_store (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_bank(wr_bank),
        .wr_addr(wr_addr), .wr_data(wr_data), .rd_en(rd_fire),
        .rd_zero(rd_empty), .rd_bank(cur_bank), .rd_addr(rd_ptr),
        .rd_data(cpu_rd_data)
    );

    obc_bank_seq #(
        .BANK_BYTES(BANK_BYTES), .CNT_W(CNT_W), .AW(AW)
    ) u_seq (
        .clk(clk), .rst_n(rst_n), .dual(cfg_dual_bank),
        .auto_rel(cfg_auto_release), .commit(commit),
        .commit_bank(commit_bank), .commit_count(commit_count),
        .clr_rx(cpu_clr_rx_done), .clr_ctl(cpu_clr_bank_ctl),
        .cpu_rd(cpu_rd), .bank_full(bank_full), .cur_bank(cur_bank),
        .rd_ptr(rd_ptr), .rd_fire(rd_fire), .rd_empty(rd_empty),
        .rx_flag(rx_done), .ctl_flag(bank_ctl), .rwal_flag(rd_allowed),
        .cur_count(byte_count)
    );

    // Endpoint interrupt: receive-done gated by its enable.
    always_comb irq = rx_done && cfg_irq_en;
endmodule

// File: rtl/obc_checker.sv
// Assertion checker for the OUT endpoint bank controller, bound to the top.
module obc_checker #(
    parameter int DATA_W = 8,
    parameter int CNT_W  = 7
) (
    input logic              clk,
    input logic              rst_n,
    input logic              cfg_auto_release,
    input logic              cfg_irq_en,
    input logic              hs_valid,
    input logic              cpu_clr_rx_done,
    input logic              cpu_clr_bank_ctl,
    input logic              cpu_rd,
    input logic [DATA_W-1:0] cpu_rd_data,
    input logic              rx_done,
    input logic              bank_ctl,
    input logic              rd_allowed,
    input logic [CNT_W-1:0]  byte_count,
    input logic              irq
);
    AST_HS_SINGLE_PULSE: assert property (@(posedge clk) disable iff (!rst_n)
        hs_valid |=> !hs_valid); // R2
    AST_IRQ_NEEDS_ENABLE: assert property (@(posedge clk) disable iff (!rst_n)
        irq |-> (cfg_irq_en && rx_done)); // R4
    AST_RX_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
        (rx_done && !cpu_clr_rx_done) |=> rx_done); // R5
    AST_ORDERED_RELEASE: assert property (@(posedge clk) disable iff (!rst_n)
        (!cfg_auto_release && rx_done && bank_ctl && cpu_clr_bank_ctl) |=> bank_ctl); // R6
    AST_RWAL_NEEDS_BANK: assert property (@(posedge clk) disable iff (!rst_n)
        rd_allowed |-> (bank_ctl && byte_count != '0)); // R8
    AST_COUNT_DOWN: assert property (@(posedge clk) disable iff (!rst_n)
        (cpu_rd && rd_allowed && byte_count > CNT_W'(1)) |=> (byte_count == $past(byte_count) - CNT_W'(1))); // R9
    AST_EMPTY_READ_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (cpu_rd && !rd_allowed) |=> (cpu_rd_data == '0)); // R10
endmodule

bind usb_out_bank_ctrl obc_checker #(.DATA_W(DATA_W), .CNT_W(CNT_W)) u_obc_checker (.*);

// File: tb/tb_usb_out_bank_ctrl.sv
module tb_usb_out_bank_ctrl;
    localparam int CLK_PERIOD = 10;
    localparam int BB = 8;
    localparam int CW = $clog2(BB + 1);

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic cfg_dual_bank = 1'b0, cfg_auto_release = 1'b0, cfg_irq_en = 1'b0;
    logic pkt_start = 1'b0, pkt_byte_vld = 1'b0, pkt_end = 1'b0;
    logic [7:0] pkt_byte = '0;
    logic cpu_clr_rx_done = 1'b0, cpu_clr_bank_ctl = 1'b0, cpu_rd = 1'b0;
    logic hs_valid, hs_ack, rx_done, bank_ctl, rd_allowed, irq;
    logic [7:0] cpu_rd_data;
    logic [CW-1:0] byte_count;

    usb_out_bank_ctrl #(.BANK_BYTES(BB), .DATA_W(8)) dut (.*);

    always #(CLK_PERIOD/2) clk = ~clk;

    // Reference model
    bit m_full [2];
    int m_cnt [2];
    int m_cur, m_fsel, m_ptr;
    bit m_rx;
    int m_mem [2][BB];
    int checks = 0, errors = 0;
    bit finished = 0;

    task automatic chk(string req, string what, int act, int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s %s: actual %0d expected %0d", req, what, act, exp);
        end
    endtask

    task automatic check_flags();
        chk("R3/R5", "rx_done", rx_done, m_rx);
        chk("R7", "bank_ctl", bank_ctl, m_full[m_cur]);
        chk("R8", "rd_allowed", rd_allowed, (m_full[m_cur] && m_cnt[m_cur] > 0));
        chk("R9", "byte_count", byte_count, m_cnt[m_cur]);
        chk("R4", "irq", irq, (m_rx && cfg_irq_en));
    endtask

    function automatic void model_release();
        m_full[m_cur] = 0;
        m_cnt[m_cur]  = 0;
        m_cur = cfg_dual_bank ? 1 - m_cur : 0;
        m_ptr = 0;
        if (m_full[m_cur]) m_rx = 1;
    endfunction

    task automatic do_reset(bit dual, bit autor);
        @(negedge clk);
        rst_n = 0; cfg_dual_bank = dual; cfg_auto_release = autor;
        repeat (3) @(negedge clk);
        rst_n = 1;
        m_full[0] = 0; m_full[1] = 0; m_cnt[0] = 0; m_cnt[1] = 0;
        m_cur = 0; m_fsel = 0; m_ptr = 0; m_rx = 0;
    endtask

    task automatic send_pkt(int n, int base, string req);
        int sel;
        bit acc;
        @(negedge clk);
        pkt_start = 1;
        sel = cfg_dual_bank ? m_fsel : 0;
        acc = !m_full[sel];
        @(negedge clk);
        pkt_start = 0;
        for (int i = 0; i < n; i++) begin
            pkt_byte_vld = 1; pkt_byte = 8'(base + i);
            @(negedge clk);
        end
        pkt_byte_vld = 0; pkt_end = 1;
        @(negedge clk);
        pkt_end = 0;
        chk(req, "hs_valid", hs_valid, 1);
        chk(req, "hs_ack", hs_ack, acc);
        if (acc) begin
            for (int i = 0; i < n && i < BB; i++) m_mem[sel][i] = (base + i) & 8'hFF;
            m_full[sel] = 1;
            m_cnt[sel] = (n > BB) ? BB : n;
            if (sel == m_cur) m_rx = 1;
            if (cfg_dual_bank) m_fsel = 1 - m_fsel;
        end
        check_flags();
    endtask

    task automatic clr_rx();
        @(negedge clk); cpu_clr_rx_done = 1;
        @(negedge clk); cpu_clr_rx_done = 0;
        m_rx = 0;
        check_flags();
    endtask

    task automatic clr_ctl(string req);
        @(negedge clk); cpu_clr_bank_ctl = 1;
        @(negedge clk); cpu_clr_bank_ctl = 0;
        if (m_full[m_cur] && !m_rx) model_release();
        chk(req, "bank_ctl after release request", bank_ctl, m_full[m_cur]);
        check_flags();
    endtask

    task automatic rd_byte(string req);
        int exp;
        @(negedge clk); cpu_rd = 1;
        @(negedge clk); cpu_rd = 0;
        if (m_full[m_cur] && m_cnt[m_cur] > 0) begin
            exp = m_mem[m_cur][m_ptr];
            m_ptr++; m_cnt[m_cur]--;
            if (cfg_auto_release && m_cnt[m_cur] == 0) model_release();
        end else begin
            exp = 0;
        end
        chk(req, "cpu_rd_data", cpu_rd_data, exp);
        check_flags();
    endtask

    // Watchdog
    initial begin
        repeat (150000) @(posedge clk);
        if (!finished) begin
            checks++; errors++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("Simulation finished: %0d checks, %0d errors", checks, errors);
            $finish;
        end
    end

    initial begin
        void'($urandom(32'd2024));
        // Reset state
        do_reset(0, 0);
        chk("R2", "hs_valid at reset", hs_valid, 0);
        chk("R10", "rd_data at reset", cpu_rd_data, 0);
        check_flags();

        // R1/R2 single bank: second packet NAKed, R12 overflow saturates
        send_pkt(11, 8'h10, "R12");
        chk("R12", "saturated count", byte_count, BB);
        send_pkt(3, 8'h40, "R1");
        // R6: release ignored while rx_done set
        clr_ctl("R6");
        chk("R6", "bank still held", bank_ctl, 1);
        clr_rx();
        rd_byte("R9");
        rd_byte("R9");
        clr_ctl("R7");
        rd_byte("R10");
        chk("R10", "empty read keeps count", byte_count, 0);

        // R1 dual bank: two accepted, third refused; ping-pong on release
        do_reset(1, 0);
        send_pkt(4, 8'h20, "R1");
        send_pkt(5, 8'h30, "R1");
        send_pkt(2, 8'h50, "R1");
        clr_rx();
        rd_byte("R9");
        clr_ctl("R7");
        chk("R7", "rx_done reloaded from second bank", rx_done, 1);
        chk("R9", "second bank count", byte_count, 5);
        rd_byte("R9");

        // R11 auto release in dual bank
        do_reset(1, 1);
        send_pkt(2, 8'h60, "R11");
        send_pkt(1, 8'h70, "R11");
        rd_byte("R11");
        rd_byte("R11");
        chk("R11", "auto switch raised rx_done", rx_done, 1);
        chk("R11", "next bank count", byte_count, 1);
        clr_rx();
        rd_byte("R11");
        chk("R11", "both banks free", bank_ctl, 0);

        // Random phases over all mode combinations
        for (int mode = 0; mode < 4; mode++) begin
            do_reset(mode[0], mode[1]);
            for (int k = 0; k < 300; k++) begin
                int r;
                cfg_irq_en = 1'($urandom % 2);
                r = $urandom % 10;
                if (r < 3)      send_pkt($urandom % (BB + 3), $urandom % 256, "R2");
                else if (r < 5) clr_rx();
                else if (r < 7) clr_ctl("R7");
                else            rd_byte("R9");
            end
        end

        finished = 1;
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule